// File: doc/BRIEF.md
# Packed Double-Precision Class Test Unit

This unit tests up to eight IEEE-754 double-precision lanes of a 512-bit source vector against a set of special-value categories. An 8-bit selector picks the categories of interest, and each lane produces one result bit. That bit is set when the lane's value falls in any selected category.

A vector-length select limits the active lanes to 2, 4 or 8. A broadcast flag makes every active lane test lane 0 instead of its own slice. An optional write mask zeroes the result bits of the lanes it disables. A denormals-are-zero control makes denormal inputs classify as signed zeros.

A 4-bit reserved operand field must be all ones. Any other value flags the request as illegal, and no result is delivered for it. Each accepted request is answered one clock later with a registered mask and a valid strobe.

Top module: `fp64_class_unit`

## Requirements
- R1: Each lane is split into sign (bit 63), exponent (bits 62:52) and mantissa (bits 51:0). A NaN has exponent 0x7FF and a nonzero mantissa. It is quiet when mantissa bit 51 is 1 and signaling when that bit is 0. Infinities have exponent 0x7FF and a zero mantissa.
- R2: The categories map to selector bits as follows:
  - bit 0: quiet NaN
  - bit 1: +0
  - bit 2: -0
  - bit 3: +infinity
  - bit 4: -infinity
  - bit 5: denormal (exponent 0, mantissa nonzero)
  - bit 6: negative finite
  - bit 7: signaling NaN
- R3: A lane's result bit is set when the lane matches at least one category whose selector bit is 1. Bit j of the result belongs to lane j, which is source bits 64j+63:64j.
- R4: When `daz` is 1, an input with exponent 0 is treated as having a zero mantissa. A denormal then matches the zero category of its own sign and never matches the denormal category.
- R5: A value is negative finite when its sign is 1, its exponent is not 0x7FF and it is not zero. With `daz` clear, a negative denormal therefore matches both the denormal and the negative-finite categories.
- R6: When `mask_en` is 1, every lane whose `wmask` bit is 0 gives a result bit of 0. When `mask_en` is 0, `wmask` has no effect.
- R7: `vlen` sets the number of active lanes: 0 gives 2 lanes, 1 gives 4 lanes, and 2 or 3 give 8 lanes. Result bits at and above the active lane count are 0.
- R8: When `bcast` is 1, every active lane classifies source bits 63:0.
- R9: A request whose `rsv` field is not 4'b1111 raises `illegal` for one cycle. It leaves `res_valid` low and `res_mask` at 0.
- R10: When `in_valid` is high at a clock edge, the outputs show that request's result after that edge, and `res_valid` stays high for one cycle only. `rst` is synchronous and active high, and it clears `res_mask`, `res_valid` and `illegal`. Between requests, `res_mask` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src | input | 512 | Eight packed double-precision lanes |
| vlen | input | 2 | Active lane count select |
| bcast | input | 1 | Classify lane 0 in every lane |
| mask_en | input | 1 | Enable the write mask |
| wmask | input | 8 | Per-lane write mask |
| daz | input | 1 | Denormals-are-zero |
| sel | input | 8 | Category selector |
| rsv | input | 4 | Reserved field, must be 4'b1111 |
| res_mask | output | 8 | Registered per-lane result |
| res_valid | output | 1 | Result strobe |
| illegal | output | 1 | Illegal-encoding strobe |

## Verification
The hardest situation to reach is a denormal whose class depends on both `daz` and its sign. A negative denormal must land in two categories with `daz` clear, and in only the -0 category with it set. A single selector bit cannot reveal whether the lane matched one category or two. The stimulus table therefore pairs each boundary encoding with both settings of `daz`, and checks each entry under several random selectors plus single-category selectors. Lane-placement effects are exercised with a vector holding a different class in every lane, under each vector length, write mask and broadcast setting.

// File: rtl/fp64_class_unit.sv
module fp64_class_unit #(
  parameter int LANES = 8,
  parameter int LW    = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [LANES*LW-1:0] src,
  input  logic [1:0]         vlen,
  input  logic               bcast,
  input  logic               mask_en,
  input  logic [LANES-1:0]   wmask,
  input  logic               daz,
  input  logic [7:0]         sel,
  input  logic [3:0]         rsv,
  output logic [LANES-1:0]   res_mask,
  output logic               res_valid,
  output logic               illegal
);

  function automatic logic [7:0] classify(input logic [63:0] v, input logic dz);
    logic neg, e_one, e_zero, m_zero, is_zero;
    neg     = v[63];
    e_one   = (v[62:52] == 11'h7FF);
    e_zero  = (v[62:52] == 11'h000);
    m_zero  = (v[51:0] == 52'd0) || (e_zero && dz);
    is_zero = e_zero && m_zero;
    classify = {e_one && !m_zero && !v[51],
                neg && !e_one && !is_zero,
                e_zero && !m_zero,
                neg && e_one && m_zero,
                !neg && e_one && m_zero,
                neg && is_zero,
                !neg && is_zero,
                e_one && !m_zero && v[51]};
  endfunction

  logic [LANES-1:0] hit, active, keep, next_mask;
  logic             legal;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [LW-1:0] lane_v;
      assign lane_v = bcast ? src[LW-1:0] : src[g*LW +: LW];
      assign hit[g] = |(classify(lane_v, daz) & sel);
      assign active[g] = (vlen == 2'd0) ? (g < 2) :
                         (vlen == 2'd1) ? (g < 4) : 1'b1;
    end
  endgenerate

  assign keep      = mask_en ? wmask : {LANES{1'b1}};
  assign next_mask = hit & active & keep;
  assign legal     = (rsv == 4'b1111);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_mask  <= '0;
      res_valid <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      res_valid <= in_valid && legal;
      illegal   <= in_valid && !legal;
      if (in_valid) res_mask <= legal ? next_mask : '0;
    end
  end

endmodule

module fp64_class_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [1:0] vlen,
  input logic       mask_en,
  input logic [7:0] wmask,
  input logic [3:0] rsv,
  input logic [7:0] res_mask,
  input logic       res_valid,
  input logic       illegal
);
  // R9
  exclusive_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && illegal));
  // R10
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid) && $past(rsv) == 4'b1111);
  // R9
  illegal_follows_bad_rsv_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $past(in_valid) && $past(rsv) != 4'b1111 && res_mask == 8'h00);
  // R7
  two_lane_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(vlen) == 2'd0) |-> res_mask[7:2] == 6'd0);
  // R7
  four_lane_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(vlen) == 2'd1) |-> res_mask[7:4] == 4'd0);
  // R6
  masked_lanes_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(mask_en)) |-> (res_mask & ~$past(wmask)) == 8'h00);
  // R10
  mask_holds_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid) && !$past(rst)) |-> $stable(res_mask));
endmodule

bind fp64_class_unit fp64_class_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .vlen(vlen), .mask_en(mask_en),
  .wmask(wmask), .rsv(rsv), .res_mask(res_mask), .res_valid(res_valid),
  .illegal(illegal)
);

// File: tb/fp64_class_unit_test.sv
module fp64_class_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;
  // {value, daz, expected category bits}
  localparam logic [72:0] VEC [0:NV-1] = '{
    {64'h0000_0000_0000_0000, 1'b0, 8'h02},
    {64'h8000_0000_0000_0000, 1'b0, 8'h04},
    {64'h7FF0_0000_0000_0000, 1'b0, 8'h08},
    {64'hFFF0_0000_0000_0000, 1'b1, 8'h10},
    {64'h0000_0000_0000_0001, 1'b0, 8'h20},
    {64'h0000_0000_0000_0001, 1'b1, 8'h02},
    {64'h000F_FFFF_FFFF_FFFF, 1'b0, 8'h20},
    {64'h000F_FFFF_FFFF_FFFF, 1'b1, 8'h02},
    {64'h8000_0000_0000_0001, 1'b0, 8'h60},
    {64'h8000_0000_0000_0001, 1'b1, 8'h04},
    {64'h800F_FFFF_FFFF_FFFF, 1'b0, 8'h60},
    {64'h7FF8_0000_0000_0000, 1'b0, 8'h01},
    {64'hFFF8_0000_0000_0001, 1'b1, 8'h01},
    {64'h7FF0_0000_0000_0001, 1'b0, 8'h80},
    {64'hFFF7_FFFF_FFFF_FFFF, 1'b1, 8'h80},
    {64'h3FF0_0000_0000_0000, 1'b0, 8'h00},
    {64'hBFF0_0000_0000_0000, 1'b1, 8'h40},
    {64'hFFEF_FFFF_FFFF_FFFF, 1'b0, 8'h40},
    {64'h0010_0000_0000_0000, 1'b1, 8'h00},
    {64'h8000_0000_0000_0000, 1'b1, 8'h04}
  };

  logic clk = 0, rst = 1, in_valid = 0, bcast = 0, mask_en = 0, daz = 0;
  logic [511:0] src = '0;
  logic [1:0] vlen = 2'd2;
  logic [7:0] wmask = 8'hFF, sel = 8'h00, res_mask;
  logic [3:0] rsv = 4'hF;
  logic res_valid, illegal;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp64_class_unit uut (.clk(clk), .rst(rst), .in_valid(in_valid), .src(src),
    .vlen(vlen), .bcast(bcast), .mask_en(mask_en), .wmask(wmask), .daz(daz),
    .sel(sel), .rsv(rsv), .res_mask(res_mask), .res_valid(res_valid),
    .illegal(illegal));

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue();
    @(negedge clk) in_valid = 1;
    @(negedge clk) in_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset", {res_valid, illegal, res_mask}, 10'h000);
    rst = 0;

    // R1 R2 R3 R4 R5 table walk, all lanes same value
    for (int i = 0; i < NV; i++) begin
      src = {8{VEC[i][72:9]}};
      daz = VEC[i][8];
      for (int k = 0; k < 6; k++) begin
        s = (k == 0) ? 8'hFF : (k == 1) ? VEC[i][7:0] : 8'($urandom);
        sel = s;
        issue();
        check($sformatf("R3 vec%0d sel=%h", i, s), {res_valid, illegal, res_mask},
              {2'b10, ((VEC[i][7:0] & s) != 0) ? 8'hFF : 8'h00});
      end
      for (int b = 0; b < 8; b++) begin
        sel = 8'(1 << b);
        issue();
        check($sformatf("R2 vec%0d bit%0d", i, b), {2'b00, res_mask},
              {2'b00, VEC[i][b] ? 8'hFF : 8'h00});
      end
    end

    // mixed lanes: +0 -0 +inf -inf qNaN sNaN -1.0 denorm
    daz = 0;
    src = {64'h0000_0000_0000_0001, 64'hBFF0_0000_0000_0000,
           64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0000,
           64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000,
           64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000};
    sel = 8'hFF; issue();
    check("R3 mixed all", {res_valid, illegal, res_mask}, 10'h2FF);
    sel = 8'h01; issue();
    check("R3 lane order qnan", {2'b00, res_mask}, 10'h010);
    sel = 8'h88; issue();
    check("R1 inf and snan lanes", {2'b00, res_mask}, 10'h024);
    vlen = 2'd0; sel = 8'hFF; issue();
    check("R7 two lanes", {2'b00, res_mask}, 10'h003);
    vlen = 2'd1; issue();
    check("R7 four lanes", {2'b00, res_mask}, 10'h00F);
    vlen = 2'd3; issue();
    check("R7 code3 eight lanes", {2'b00, res_mask}, 10'h0FF);
    vlen = 2'd2; mask_en = 1; wmask = 8'hA5; issue();
    check("R6 zeroing mask", {2'b00, res_mask}, 10'h0A5);
    mask_en = 0; wmask = 8'h00; issue();
    check("R6 mask disabled", {2'b00, res_mask}, 10'h0FF);
    bcast = 1; sel = 8'h02; issue();
    check("R8 broadcast", {2'b00, res_mask}, 10'h0FF);
    vlen = 2'd1; issue();
    check("R8 broadcast four lanes", {2'b00, res_mask}, 10'h00F);
    sel = 8'h04; vlen = 2'd2; issue();
    check("R8 broadcast no -0", {2'b00, res_mask}, 10'h000);
    bcast = 0; sel = 8'h02; issue();
    check("R8 off lane own", {2'b00, res_mask}, 10'h001);

    // R9 illegal encoding
    sel = 8'hFF; rsv = 4'b1110; issue();
    check("R9 illegal", {res_valid, illegal, res_mask}, 10'h100);
    rsv = 4'b0111; issue();
    check("R9 illegal other", {res_valid, illegal, res_mask}, 10'h100);
    rsv = 4'hF; issue();
    @(negedge clk);
    check("R10 one-cycle valid and hold", {res_valid, illegal, res_mask}, 10'h0FF);

    // R10 reset mid-run
    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    check("R10 reset clears", {res_valid, illegal, res_mask}, 10'h000);
    finish_run();
  end
endmodule